// File: doc/BRIEF.md
# Coded-Prescaler PWM Generator

A single-channel pulse-width modulator driven by a small register bank. The
block runs on a 24 MHz reference clock. A 4-bit code in the control word
picks a division ratio from a sparse table of non-power-of-two values. The
selected ratio produces a one-cycle counting tick. A 16-bit counter advances
on each tick and forms a waveform with a programmable period, duty count and
active level.

Software programs the timing word and then starts the channel through the
control word. To change the division code, software first closes the tick
gate, then rewrites the code, then opens the gate again. While the gate is
closed, the divider and the counter keep their state, so the waveform goes on
from where it stopped. A new period and duty written while the channel runs
are held back until the current period ends, so no cycle is ever cut short.

Top module: `pwm_coded_div`

## Requirements
- R1: After reset, both registers read as zero. With the control word at zero, `pwm_out` sits at the inactive level of an inverted channel, which is 1.
- R2: Writes take effect on a clock edge with `wr_en` high, and `rd_data` shows the register at `addr` in the same cycle. Address 0 is the control word and keeps bits [6:0]; its bits [31:7] read as 0. Address 1 is the timing word: period field in bits [31:16], duty in bits [15:0], all 32 bits kept. Addresses 2 and 3 read as 0 and ignore writes.
- R3: Control bits [3:0] hold the division code. Codes 0, 1, 2, 3 and 4 make the counter advance once every 120, 180, 240, 360 and 480 reference cycles.
- R4: Codes 8, 9, 10, 11 and 12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1, so the counter advances every reference cycle.
- R5: Codes 5, 6, 7, 13 and 14 produce no tick. The counter holds and `pwm_out` does not toggle.
- R6: With period field P, one period lasts P+1 ticks and the count runs 0..P. The output is at its active level while the count is below the duty value, and at its inactive level otherwise. The count starts at 0 in the cycle after the run bit is set.
- R7: A duty of 0 gives a constant inactive level. A duty of P+1 or more gives a constant active level.
- R8: Control bit 5 sets the level: 1 makes the active level high, 0 makes the active level low (inverted output).
- R9: Control bit 4 is the run bit. While it is 0, `pwm_out` holds the inactive level and the divider and counter are cleared to 0. Clearing it leaves the other control fields as written.
- R10: Control bit 6 is the tick gate. While it is 0 with run set, the divider and counter keep their values and `pwm_out` is at the inactive level. When the gate opens again, counting goes on from the held count.
- R11: A timing write made while the channel runs takes effect at the next period boundary. While the run bit is 0, the latest timing word is taken up at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (2) | Word address of the register access |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the register at `addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
Some properties are checked on every cycle by the assertions. The count never goes past the active period. The period and duty in use change only when the count returns to zero, or while the channel is stopped. A closed gate freezes the divider and the counter. An invalid code never yields a tick. A stopped channel with no register write keeps its output steady. The bench scenarios show what needs a whole waveform: the division ratios seen as output edges over thousands of cycles, the duty extremes, polarity, the count carrying on after the gate reopens, and the sequence of old and new timing around a deferred update.

// File: rtl/pwm_cd_pkg.sv
package pwm_cd_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int CODE_W = 4;
    localparam int DIV_W  = 17;

    // control word layout, bit 6 down to bit 0
    typedef struct packed {
        logic              gate;       // tick gate
        logic              level_high; // 1: active high
        logic              run;        // channel enable
        logic [CODE_W-1:0] code;       // division code
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [CNT_W-1:0] per;   // period minus one
        logic [CNT_W-1:0] duty;  // active count
    } timing_t;

    // ratio for a division code, zero for codes that give no tick
    function automatic logic [DIV_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
        logic [DIV_W-1:0] r;
        case (c)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            4'd15:   r = DIV_W'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_cd_regs.sv
module pwm_cd_regs
    import pwm_cd_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output timing_t           timing
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(1);

    ctrl_t   ctrl_q;
    timing_t tim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tim_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (addr == A_TIM)  tim_q  <= timing_t'(wr_data);
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rd_data = DATA_W'(ctrl_q);
            A_TIM:   rd_data = DATA_W'(tim_q);
            default: rd_data = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign timing = tim_q;

    // R2: a register changes only through a write strobe
    assert_reg_write_only_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(ctrl_q) && $stable(tim_q)));

endmodule

// File: rtl/pwm_cd_prescaler.sv
module pwm_cd_prescaler
    import pwm_cd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              run,
    input  logic              gate,
    output logic              tick
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] last;
    logic             valid;
    logic [DIV_W-1:0] div_q;

    assign ratio = ratio_of(code);
    assign valid = (ratio != '0);
    assign last  = ratio - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (gate && valid) begin
            if (div_q >= last) div_q <= '0;
            else               div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = run && gate && valid && (div_q >= last);

    // R10: a closed gate freezes the divider
    assert_div_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $past(run && !gate) |-> $stable(div_q));

    // R9: a stopped channel leaves the divider at zero
    assert_div_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!run) |-> (div_q == '0));

endmodule

// File: rtl/pwm_cd_wave.sv
module pwm_cd_wave
    import pwm_cd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    run,
    input  logic    gate,
    input  logic    level_high,
    input  timing_t shadow,
    output logic    pwm_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            per_q  <= shadow.per;
            duty_q <= shadow.duty;
        end else if (tick) begin
            if (cnt_q >= per_q) begin
                cnt_q  <= '0;
                per_q  <= shadow.per;
                duty_q <= shadow.duty;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign active  = (cnt_q < duty_q);
    assign pwm_out = (run && gate && active) ? level_high : !level_high;

    // R6: the count stays inside the active period
    assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= per_q);

    // R10: a closed gate freezes the count
    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $past(run && !gate) |-> $stable(cnt_q));

    // R11: running timing changes only at the period boundary
    assert_defer_update_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !($stable(per_q) && $stable(duty_q))) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_coded_div.sv
module pwm_coded_div
    import pwm_cd_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    ctrl_t   ctrl;
    timing_t timing;
    logic    tick;

    pwm_cd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .timing  (timing)
    );

    pwm_cd_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .code (ctrl.code),
        .run  (ctrl.run),
        .gate (ctrl.gate),
        .tick (tick)
    );

    pwm_cd_wave u_wave (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .run        (ctrl.run),
        .gate       (ctrl.gate),
        .level_high (ctrl.level_high),
        .shadow     (timing),
        .pwm_out    (pwm_out)
    );

    // R5: a code outside the table never yields a tick
    assert_invalid_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (ratio_of(ctrl.code) == '0) |-> !tick);

    // R9: a stopped channel with no writes keeps its output steady
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!ctrl.run && !wr_en) |-> $stable(pwm_out));

endmodule

// File: tb/pwm_coded_div_bench.sv
`timescale 1ns/1ps
module pwm_coded_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    pwm_coded_div u_pwm_coded_div (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // returns at the sampling point of the first cycle after the write edge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mk(int code, bit run, bit hi, bit gate);
        return {25'd0, gate, hi, run, code[3:0]};
    endfunction

    task automatic cfg(int code, bit hi, int per, int duty);
        wr(2'd0, mk(code, 1'b0, hi, 1'b1));
        wr(2'd1, {per[15:0], duty[15:0]});
        wr(2'd0, mk(code, 1'b1, hi, 1'b1));
    endtask

    // divide-by-1 waveform, starting at count 'start'
    task automatic run_check(string req, int per, int duty, bit hi, int start, int n);
        for (int k = 0; k < n; k++) begin
            logic e;
            e = (((start + k) % (per + 1)) < duty) ? hi : !hi;
            chk(req, 32'(pwm_out), 32'(e));
            step();
        end
    endtask

    task automatic t_reset();
        chk("R1 output", 32'(pwm_out), 32'd1);
        addr = 2'd0; #1; chk("R1 ctrl", rd_data, 32'd0);
        addr = 2'd1; #1; chk("R1 timing", rd_data, 32'd0);
    endtask

    task automatic t_regs();
        wr(2'd0, 32'hFFFF_FFFF);
        addr = 2'd0; #1; chk("R2 ctrl readback", rd_data, 32'h0000_007F);
        wr(2'd1, 32'hA5A5_5A5A);
        addr = 2'd1; #1; chk("R2 timing readback", rd_data, 32'hA5A5_5A5A);
        wr(2'd2, 32'h1234_5678);
        addr = 2'd2; #1; chk("R2 unused addr", rd_data, 32'd0);
        addr = 2'd1; #1; chk("R2 unused write", rd_data, 32'hA5A5_5A5A);
        wr(2'd0, 32'd0);
    endtask

    task automatic t_basic();
        cfg(15, 1'b1, 7, 3);
        run_check("R6 P7 D3", 7, 3, 1'b1, 0, 24);
        cfg(15, 1'b1, 2, 1);
        run_check("R6 P2 D1", 2, 1, 1'b1, 0, 9);
    endtask

    task automatic t_duty_edges();
        cfg(15, 1'b1, 4, 0);
        run_check("R7 duty zero", 4, 0, 1'b1, 0, 12);
        cfg(15, 1'b1, 4, 5);
        run_check("R7 duty P+1", 4, 5, 1'b1, 0, 12);
        cfg(15, 1'b1, 4, 16'hFFFF);
        run_check("R7 duty max", 4, 16'hFFFF, 1'b1, 0, 12);
    endtask

    task automatic t_polarity();
        cfg(15, 1'b0, 4, 2);
        run_check("R8 inverted", 4, 2, 1'b0, 0, 15);
    endtask

    task automatic t_disable();
        cfg(15, 1'b1, 3, 2);
        step(); step();
        wr(2'd0, mk(15, 1'b0, 1'b1, 1'b1));
        for (int k = 0; k < 20; k++) begin
            chk("R9 stopped low", 32'(pwm_out), 32'd0);
            step();
        end
        addr = 2'd0; #1; chk("R9 fields kept", rd_data, mk(15, 1'b0, 1'b1, 1'b1));
        wr(2'd0, mk(15, 1'b0, 1'b0, 1'b1));
        for (int k = 0; k < 10; k++) begin
            chk("R9 stopped inverted", 32'(pwm_out), 32'd1);
            step();
        end
        wr(2'd0, mk(15, 1'b1, 1'b1, 1'b1));
        run_check("R9 restart from zero", 3, 2, 1'b1, 0, 8);
    endtask

    task automatic t_gate();
        cfg(15, 1'b1, 9, 5);
        wr(2'd0, mk(15, 1'b1, 1'b1, 1'b0));
        for (int k = 0; k < 6; k++) begin
            chk("R10 gated inactive", 32'(pwm_out), 32'd0);
            step();
        end
        wr(2'd0, mk(15, 1'b1, 1'b1, 1'b1));
        run_check("R10 resume held count", 9, 5, 1'b1, 2, 12);
    endtask

    task automatic t_defer();
        cfg(15, 1'b1, 9, 3);
        step(); step(); step();
        wr(2'd1, {16'd4, 16'd4});
        run_check("R11 old values kept", 9, 3, 1'b1, 5, 5);
        run_check("R11 new values at boundary", 4, 4, 1'b1, 0, 10);
    endtask

    task automatic pre_chk(string req, int code, int ratio, bit full);
        cfg(code, 1'b1, 1, 1);
        repeat (ratio - 1) step();
        chk(req, 32'(pwm_out), 32'd1);
        step();
        chk(req, 32'(pwm_out), 32'd0);
        if (full) begin
            repeat (ratio - 1) step();
            chk(req, 32'(pwm_out), 32'd0);
            step();
            chk(req, 32'(pwm_out), 32'd1);
        end
    endtask

    task automatic t_prescale_low();
        pre_chk("R3 code0 /120", 0, 120, 1'b1);
        pre_chk("R3 code1 /180", 1, 180, 1'b1);
        pre_chk("R3 code2 /240", 2, 240, 1'b1);
        pre_chk("R3 code3 /360", 3, 360, 1'b1);
        pre_chk("R3 code4 /480", 4, 480, 1'b1);
    endtask

    task automatic t_prescale_high();
        pre_chk("R4 code8 /12000", 8, 12000, 1'b0);
        pre_chk("R4 code12 /72000", 12, 72000, 1'b0);
        pre_chk("R4 code15 /1", 15, 1, 1'b1);
    endtask

    task automatic t_invalid();
        int bad_codes[5] = '{5, 6, 7, 13, 14};
        foreach (bad_codes[i]) begin
            int  toggles;
            logic prev;
            cfg(bad_codes[i], 1'b1, 1, 1);
            toggles = 0;
            prev = pwm_out;
            for (int k = 0; k < 200; k++) begin
                if (pwm_out !== prev) toggles++;
                prev = pwm_out;
                step();
            end
            chk("R5 no toggles", 32'(toggles), 32'd0);
            chk("R5 held level", 32'(pwm_out), 32'd1);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_regs();
        t_basic();
        t_duty_edges();
        t_polarity();
        t_disable();
        t_gate();
        t_defer();
        t_invalid();
        t_prescale_low();
        t_prescale_high();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule